// File: doc/BRIEF.md
# Keyed Write-Protect Guard for a Flash Controller Register Bank

This block sits on the register write path of a flash controller and decides which writes may take effect. It owns the controller's control register, whose bit 1 is a write-protect flag. While that flag is set, writes to the control register and to every ordinary register behind the guard are dropped. A dropped write raises a sticky error bit that software reads back and clears.

The protect flag cannot be changed by a plain write, and this holds even when protection is off. Software must first write three key words in a fixed order to two key registers. When the last key lands, the guard grants a one-shot permission, and the next write to the control register then loads every bit, the flag included. The permission is used up by the first write that follows, whatever its address. A wrong write in the middle of the key order throws the sequence back to its start.

The bus is a single-cycle write port made of a strobe, an address and a 32-bit data word. The guard drives a write enable for the ordinary registers behind it and exposes the control register, the protect flag, the permission and the error bit.

Top module: `wpu_guard`

## Requirements
- R1: After reset, ctl_o reads 0x0000_0002, meaning the protect flag in bit 1 is set and all other bits are zero. prot_o is 1, arm_o is 0, err_o is 0, and the key sequence waits for its first step.
- R2: While prot_o is 1 and arm_o is 0, a write to the control register at address 0x00 leaves ctl_o unchanged. A write to any address other than 0x00, 0x18, 0x1c or 0x2c keeps fwd_we_o low during that cycle.
- R3: When arm_o is 0 and prot_o is 0, a write to 0x00 loads every bit of ctl_o except bit 1, which keeps its old value.
- R4: Writing 0x7123 to 0x18, then 0x812a to 0x1c, then 0xbee1 to 0x18, as consecutive bus writes, sets arm_o from the clock edge that takes the third write.
- R5: While arm_o is 1, a write to 0x00 loads all bits of ctl_o, bit 1 included. The first write of any address after arm_o rose clears arm_o, and a later control write is then treated as unarmed.
- R6: err_o is sticky. A write to the status register at 0x2c with data bit 1 equal to 1 clears it. A write there with data bit 1 equal to 0 leaves it unchanged.
- R7: A write that is dropped under R2 sets err_o. Writes to 0x18, 0x1c and 0x2c are never blocked and never set err_o. When prot_o is 0, a write to any other non-control address raises fwd_we_o in that cycle.
- R8: Any write that does not match the expected next key step sends the sequence back to its first step. This includes writes to other addresses. If that write is itself the first key word, it counts as step one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 32 | Write data |
| ctl_o | output | 32 | Control register contents |
| prot_o | output | 1 | Write-protect flag (control bit 1) |
| arm_o | output | 1 | One-shot permission for the next control write |
| err_o | output | 1 | Sticky protect-violation error (status bit 1) |
| fwd_we_o | output | 1 | Gated write enable for the registers behind the guard |

## Verification
The bench goes after the key order. It sends a wrong word in the middle of the sequence, a repeated first key and a foreign write between two keys. A sequencer that forgot to restart would grant permission after the foreign write, and one that did not reuse a repeated first key would refuse a legitimate retry. The bench also spends the permission on a write to another register and then tries to use it for a control write. A guard that kept the permission alive would drop protection there, and the bench sees that as a changed ctl_o and no error. Plain control writes with protection off must keep bit 1 and still move the other bits. Writing zero to the status error bit must not clear it.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
   typedef enum logic [1:0] {
      KS_IDLE = 2'd0,
      KS_GOT1 = 2'd1,
      KS_GOT2 = 2'd2
   } key_step_e;
endpackage

// File: rtl/wpu_key_seq.sv
module wpu_key_seq #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter logic [ADDR_W-1:0] KEY_A_ADDR = 'h18,
   parameter logic [ADDR_W-1:0] KEY_B_ADDR = 'h1c,
   parameter logic [DATA_W-1:0] KEY_0 = 'h7123,
   parameter logic [DATA_W-1:0] KEY_1 = 'h812a,
   parameter logic [DATA_W-1:0] KEY_2 = 'hbee1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              arm_o
);
   import wpu_pkg::*;

   key_step_e step_q, step_d;
   logic      hit0, hit1, hit2, done;

   assign hit0 = (wr_addr_i == KEY_A_ADDR) && (wr_data_i == KEY_0);
   assign hit1 = (wr_addr_i == KEY_B_ADDR) && (wr_data_i == KEY_1);
   assign hit2 = (wr_addr_i == KEY_A_ADDR) && (wr_data_i == KEY_2);

   always_comb begin
      step_d = step_q;
      done   = 1'b0;
      if (wr_en_i) begin
         unique case (step_q)
            KS_GOT1: step_d = hit1 ? KS_GOT2 : (hit0 ? KS_GOT1 : KS_IDLE);
            KS_GOT2: begin
               done   = hit2;
               step_d = hit0 ? KS_GOT1 : KS_IDLE;
            end
            default: step_d = hit0 ? KS_GOT1 : KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         step_q <= KS_IDLE;
         arm_o  <= 1'b0;
      end else begin
         step_q <= step_d;
         if (done)
            arm_o <= 1'b1;
         else if (wr_en_i)
            arm_o <= 1'b0;
      end
   end
endmodule

// File: rtl/wpu_ctl_reg.sv
module wpu_ctl_reg #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WP_BIT  = 1,
   parameter logic [DATA_W-1:0] CTL_RST = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              we_i,
   input  logic              armed_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] ctl_q_o
);
   localparam logic [DATA_W-1:0] WP_MASK  = DATA_W'(1) << WP_BIT;
   localparam logic [DATA_W-1:0] RST_VAL  = CTL_RST | WP_MASK;

   logic [DATA_W-1:0] plain_val;
   logic              take;

   assign plain_val = (wdata_i & ~WP_MASK) | (ctl_q_o & WP_MASK);
   assign take      = we_i && (armed_i || !ctl_q_o[WP_BIT]);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         ctl_q_o <= RST_VAL;
      else if (take)
         ctl_q_o <= armed_i ? wdata_i : plain_val;
   end
endmodule

// File: rtl/wpu_err_stat.sv
module wpu_err_stat (
   input  logic clk_i,
   input  logic rst_i,
   input  logic set_i,
   input  logic clr_i,
   output logic err_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i)
         err_o <= 1'b0;
      else if (set_i)
         err_o <= 1'b1;
      else if (clr_i)
         err_o <= 1'b0;
   end
endmodule

// File: rtl/wpu_guard.sv
module wpu_guard #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WP_BIT     = 1,
   parameter int unsigned ERR_BIT    = 1,
   parameter logic [ADDR_W-1:0] CTL_ADDR   = 'h00,
   parameter logic [ADDR_W-1:0] KEY_A_ADDR = 'h18,
   parameter logic [ADDR_W-1:0] KEY_B_ADDR = 'h1c,
   parameter logic [ADDR_W-1:0] STAT_ADDR  = 'h2c,
   parameter logic [DATA_W-1:0] KEY_0   = 'h7123,
   parameter logic [DATA_W-1:0] KEY_1   = 'h812a,
   parameter logic [DATA_W-1:0] KEY_2   = 'hbee1,
   parameter logic [DATA_W-1:0] CTL_RST = '0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] ctl_o,
   output logic              prot_o,
   output logic              arm_o,
   output logic              err_o,
   output logic              fwd_we_o
);
   initial begin
      assert (WP_BIT < DATA_W) else $error("WP_BIT outside data word");
      assert (ERR_BIT < DATA_W) else $error("ERR_BIT outside data word");
      assert (KEY_A_ADDR != KEY_B_ADDR) else $error("key addresses must differ");
      assert (CTL_ADDR != STAT_ADDR) else $error("control and status collide");
   end

   logic is_ctl, is_key, is_stat, is_other;
   logic ctl_wr, other_wr, reject, stat_clr;

   assign is_ctl   = (wr_addr_i == CTL_ADDR);
   assign is_key   = (wr_addr_i == KEY_A_ADDR) || (wr_addr_i == KEY_B_ADDR);
   assign is_stat  = (wr_addr_i == STAT_ADDR);
   assign is_other = !is_ctl && !is_key && !is_stat;

   assign ctl_wr   = wr_en_i && is_ctl;
   assign other_wr = wr_en_i && is_other;
   assign reject   = prot_o && ((ctl_wr && !arm_o) || other_wr);
   assign stat_clr = wr_en_i && is_stat && wr_data_i[ERR_BIT];
   assign fwd_we_o = other_wr && !prot_o;
   assign prot_o   = ctl_o[WP_BIT];

   wpu_key_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .KEY_A_ADDR(KEY_A_ADDR), .KEY_B_ADDR(KEY_B_ADDR),
      .KEY_0(KEY_0), .KEY_1(KEY_1), .KEY_2(KEY_2)
   ) seq_i (
      .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .arm_o(arm_o)
   );

   wpu_ctl_reg #(
      .DATA_W(DATA_W), .WP_BIT(WP_BIT), .CTL_RST(CTL_RST)
   ) ctl_i (
      .clk_i(clk_i), .rst_i(rst_i), .we_i(ctl_wr), .armed_i(arm_o),
      .wdata_i(wr_data_i), .ctl_q_o(ctl_o)
   );

   wpu_err_stat err_i (
      .clk_i(clk_i), .rst_i(rst_i), .set_i(reject), .clr_i(stat_clr),
      .err_o(err_o)
   );
endmodule

// File: rtl/wpu_guard_chk.sv
module wpu_guard_chk #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ERR_BIT    = 1,
   parameter logic [ADDR_W-1:0] CTL_ADDR   = 'h00,
   parameter logic [ADDR_W-1:0] KEY_A_ADDR = 'h18,
   parameter logic [ADDR_W-1:0] KEY_B_ADDR = 'h1c,
   parameter logic [ADDR_W-1:0] STAT_ADDR  = 'h2c,
   parameter logic [DATA_W-1:0] KEY_2      = 'hbee1
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [DATA_W-1:0] ctl_o,
   input logic              prot_o,
   input logic              arm_o,
   input logic              err_o,
   input logic              fwd_we_o
);
   logic ctl_armed_wr, key2_wr, plain_wr;
   assign ctl_armed_wr = wr_en_i && (wr_addr_i == CTL_ADDR) && arm_o;
   assign key2_wr      = wr_en_i && (wr_addr_i == KEY_A_ADDR) && (wr_data_i == KEY_2);
   assign plain_wr     = wr_en_i && (wr_addr_i != CTL_ADDR) && (wr_addr_i != KEY_A_ADDR)
                         && (wr_addr_i != KEY_B_ADDR) && (wr_addr_i != STAT_ADDR);

   AST_CTL_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
      (prot_o && !arm_o) |=> $stable(ctl_o)); // R2
   AST_FWD_BLOCKED: assert property (@(posedge clk_i) disable iff (rst_i)
      prot_o |-> !fwd_we_o); // R2
   AST_WP_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (rst_i)
      !ctl_armed_wr |=> $stable(prot_o)); // R3
   AST_ARM_FROM_KEY: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(arm_o) |-> $past(key2_wr)); // R4
   AST_ARM_ONESHOT: assert property (@(posedge clk_i) disable iff (rst_i)
      (arm_o && wr_en_i && !key2_wr) |=> !arm_o); // R5
   AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
      (err_o && !(wr_en_i && (wr_addr_i == STAT_ADDR) && wr_data_i[ERR_BIT])) |=> err_o); // R6
   AST_ERR_ON_BLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
      (prot_o && plain_wr) |=> err_o); // R7
endmodule

bind wpu_guard wpu_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_BIT(ERR_BIT),
   .CTL_ADDR(CTL_ADDR), .KEY_A_ADDR(KEY_A_ADDR), .KEY_B_ADDR(KEY_B_ADDR),
   .STAT_ADDR(STAT_ADDR), .KEY_2(KEY_2)
) chk_i (
   .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
   .wr_data_i(wr_data_i), .ctl_o(ctl_o), .prot_o(prot_o), .arm_o(arm_o),
   .err_o(err_o), .fwd_we_o(fwd_we_o)
);

// File: tb/wpu_guard_tb_top.sv
module wpu_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] ctl;
   logic        prot, arm, err, fwd_we;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   wpu_guard dut_i (
      .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .ctl_o(ctl), .prot_o(prot), .arm_o(arm),
      .err_o(err), .fwd_we_o(fwd_we)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // one bus write; returns at the negedge after the taking edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_fwd(input logic [7:0] a, input logic [31:0] d, input bit exp);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      #1;
      chk(fwd_we == exp, exp ? "R7 fwd_we" : "R2 fwd_we", 32'(fwd_we), 32'(exp));
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(8'h18, 32'h7123); wr(8'h1c, 32'h812a); wr(8'h18, 32'hbee1);
   endtask

   task automatic t_reset();
      chk(ctl == 32'h2, "R1 ctl", ctl, 32'h2);
      chk(prot == 1'b1, "R1 prot", 32'(prot), 1);
      chk(arm == 1'b0, "R1 arm", 32'(arm), 0);
      chk(err == 1'b0, "R1 err", 32'(err), 0);
   endtask

   task automatic t_protected();
      wr(8'h00, 32'hf0);
      chk(ctl == 32'h2, "R2 ctl kept", ctl, 32'h2);
      chk(err == 1'b1, "R7 err set by ctl", 32'(err), 1);
      wr(8'h2c, 32'h0);
      chk(err == 1'b1, "R6 zero keeps err", 32'(err), 1);
      wr(8'h2c, 32'h2);
      chk(err == 1'b0, "R6 w1c", 32'(err), 0);
      wr_fwd(8'h04, 32'h55, 1'b0);
      chk(err == 1'b1, "R7 err set by other", 32'(err), 1);
      wr(8'h2c, 32'h2);
      wr(8'h18, 32'h1234);
      chk(err == 1'b0, "R7 key write no err", 32'(err), 0);
   endtask

   task automatic t_unlock_and_clear();
      unlock();
      chk(arm == 1'b1, "R4 arm", 32'(arm), 1);
      wr(8'h00, 32'h30);
      chk(ctl == 32'h30, "R5 armed load", ctl, 32'h30);
      chk(prot == 1'b0, "R5 prot cleared", 32'(prot), 0);
      chk(arm == 1'b0, "R5 arm consumed", 32'(arm), 0);
   endtask

   task automatic t_plain_ctl();
      wr(8'h00, 32'h0e);
      chk(ctl == 32'h0c, "R3 wp held low", ctl, 32'h0c);
      wr_fwd(8'h08, 32'h1, 1'b1);
      chk(err == 1'b0, "R7 no err unprot", 32'(err), 0);
      unlock();
      wr(8'h00, 32'h02);
      chk(prot == 1'b1, "R5 prot set", 32'(prot), 1);
      chk(ctl == 32'h02, "R5 ctl", ctl, 32'h02);
   endtask

   task automatic t_bad_seq();
      wr(8'h18, 32'h7123); wr(8'h1c, 32'h9999); wr(8'h18, 32'hbee1);
      chk(arm == 1'b0, "R8 wrong middle", 32'(arm), 0);
      wr(8'h18, 32'h7123); wr(8'h1c, 32'h812a); wr_fwd(8'h04, 32'h0, 1'b0);
      wr(8'h18, 32'hbee1);
      chk(arm == 1'b0, "R8 foreign write", 32'(arm), 0);
      wr(8'h2c, 32'h2);
      wr(8'h18, 32'h7123); wr(8'h18, 32'h7123); wr(8'h1c, 32'h812a);
      wr(8'h18, 32'hbee1);
      chk(arm == 1'b1, "R8 repeated first key", 32'(arm), 1);
   endtask

   task automatic t_arm_lapse();
      // armed from previous task; spend it on a status write
      wr(8'h2c, 32'h0);
      chk(arm == 1'b0, "R5 lapse", 32'(arm), 0);
      wr(8'h00, 32'h0);
      chk(ctl == 32'h2, "R5 unarmed ctl blocked", ctl, 32'h2);
      chk(err == 1'b1, "R5 unarmed ctl err", 32'(err), 1);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_protected();
      t_unlock_and_clear();
      t_plain_ctl();
      t_bad_seq();
      t_arm_lapse();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule